// File: doc/BRIEF.md
# Eight-bit ALU with flags

This block is the arithmetic and logic stage of a small 8-bit processor. It is purely combinational. The core gives it a 4-bit operation code, two operands and the current contents of the four-bit flags register. In the same cycle it returns a result, a strobe saying whether that result goes back to the destination register, and the next value of the flags register.

Operand selection, the register file, memory access, control flow and the flags register itself sit outside the block. The core writes `flags_o` into its flags register every cycle. It writes `result_o` into the destination register only when `wr_en_o` is high. The returned flag vector keeps the processor's register layout, so the core can store it without reordering.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) drives `result_o` = (a + b) mod 256 and `wr_en_o` = 1, and sets carry (bit 0) to the ninth bit of the sum.
- R2: Code 1 (add with carry) drives `result_o` = (a + b + `flags_i[0]`) mod 256 and `wr_en_o` = 1, and sets carry to the ninth bit of that sum.
- R3: Code 2 (subtract) drives `result_o` = (a − b) mod 256 and `wr_en_o` = 1, and sets carry when a < b as unsigned numbers (borrow).
- R4: Codes 3, 4 and 5 drive a AND b, a OR b and NOT(a OR b), with `wr_en_o` = 1 and carry cleared.
- R5: Code 7 (move) drives `result_o` = b and `wr_en_o` = 1, and clears carry.
- R6: Code 6 (compare) holds `wr_en_o` = 0 and `result_o` = 0. It sets carry on a < b, zero (bit 1) when a − b is 0, equal (bit 2) when a = b, and greater (bit 3) when a > b unsigned.
- R7: For codes 0–5 and 7, zero (bit 1) of `flags_o` is set exactly when `result_o` is 0.
- R8: For codes 0–5 and 7, equal and greater (bits 2 and 3) of `flags_o` copy bits 2 and 3 of `flags_i`.
- R9: Codes 8–15 hold `wr_en_o` = 0 and `result_o` = 0, and `flags_o` equals `flags_i`.
- R10: The flag vector is ordered from bit 0 upward as carry, zero, equal, greater. Equal and greater are never both set after a compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (register or immediate) |
| flags_i | input | 4 | Current flags register: carry, zero, equal, greater from bit 0 |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result is to be written to the destination register |
| flags_o | output | 4 | Next flags register value |

## Verification
The embedded immediate assertions re-check invariants on every evaluation:
- compare and the unused codes never write;
- an unused code passes the flags through;
- the zero flag agrees with a written result;
- equal and greater survive every operation except compare;
- equal and greater are never both set;
- move passes the second operand through.

Only the bench's directed scenarios can confirm the arithmetic values themselves. That covers carry out of the ninth bit, the carry-in of add with carry, the borrow on subtract and compare, and the exact outcome of each logic operation at the operand extremes 0x00, 0xFF, 0x80 and 0x7F.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned OPW = 4;
    localparam int unsigned FW = 4;

    localparam logic [OPW-1:0] OP_ADD = 4'd0;
    localparam logic [OPW-1:0] OP_ADC = 4'd1;
    localparam logic [OPW-1:0] OP_SUB = 4'd2;
    localparam logic [OPW-1:0] OP_AND = 4'd3;
    localparam logic [OPW-1:0] OP_OR  = 4'd4;
    localparam logic [OPW-1:0] OP_NOR = 4'd5;
    localparam logic [OPW-1:0] OP_CMP = 4'd6;
    localparam logic [OPW-1:0] OP_MOV = 4'd7;

    localparam int unsigned FLG_C = 0;
    localparam int unsigned FLG_Z = 1;
    localparam int unsigned FLG_E = 2;
    localparam int unsigned FLG_G = 3;

    localparam logic [1:0] LSEL_AND = 2'd0;
    localparam logic [1:0] LSEL_OR  = 2'd1;
    localparam logic [1:0] LSEL_NOR = 2'd2;
    localparam logic [1:0] LSEL_MOV = 2'd3;

    typedef struct packed {
        logic          wr;
        logic [FW-1:0] flags;
        logic [DW-1:0] result;
    } alu_out_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o
);
    localparam int unsigned EW = W + 1;

    logic [W-1:0]  b_eff_d;
    logic          c_eff_d;
    logic [EW-1:0] ext_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        c_eff_d = sub_i ? 1'b1 : cin_i;
        ext_d   = {1'b0, a_i} + {1'b0, b_eff_d} + {{W{1'b0}}, c_eff_d};
        sum_o   = ext_d[W-1:0];
        // Subtraction through two's complement: borrow is the missing carry.
        cy_o    = sub_i ? ~ext_d[W] : ext_d[W];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int unsigned W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    import alu8_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_d;
        always_comb begin
            unique case (sel_i)
                LSEL_AND: bit_d = a_i[i] & b_i[i];
                LSEL_OR:  bit_d = a_i[i] | b_i[i];
                LSEL_NOR: bit_d = ~(a_i[i] | b_i[i]);
                default:  bit_d = b_i[i];
            endcase
        end
        assign y_o[i] = bit_d;
    end
endmodule

// File: rtl/alu8_cmp.sv
module alu8_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o,
    output logic         gt_o
);
    always_comb begin
        eq_o = (a_i == b_i);
        gt_o = (a_i > b_i);
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [FW-1:0]  flags_i,
    output logic [W-1:0]   result_o,
    output logic           wr_en_o,
    output logic [FW-1:0]  flags_o
);
    localparam logic [W-1:0] ZERO_W = '0;

    logic         sub_d;
    logic         cin_d;
    logic [W-1:0] sum_d;
    logic         cy_d;
    logic [1:0]   lsel_d;
    logic [W-1:0] lres_d;
    logic         eq_d;
    logic         gt_d;
    logic         wr_d;
    logic [FW-1:0] flags_d;
    logic [W-1:0] result_d;

    always_comb begin
        sub_d  = (op_i == OP_SUB) || (op_i == OP_CMP);
        cin_d  = (op_i == OP_ADC) ? flags_i[FLG_C] : 1'b0;
        unique case (op_i)
            OP_AND:  lsel_d = LSEL_AND;
            OP_OR:   lsel_d = LSEL_OR;
            OP_NOR:  lsel_d = LSEL_NOR;
            default: lsel_d = LSEL_MOV;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .a_i  (a_i),
        .b_i  (b_i),
        .cin_i(cin_d),
        .sub_i(sub_d),
        .sum_o(sum_d),
        .cy_o (cy_d)
    );

    alu8_logic #(.W(W)) u_logic (
        .sel_i(lsel_d),
        .a_i  (a_i),
        .b_i  (b_i),
        .y_o  (lres_d)
    );

    alu8_cmp #(.W(W)) u_cmp (
        .a_i (a_i),
        .b_i (b_i),
        .eq_o(eq_d),
        .gt_o(gt_d)
    );

    always_comb begin
        wr_d     = 1'b0;
        result_d = ZERO_W;
        flags_d  = flags_i;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB: begin
                wr_d           = 1'b1;
                result_d       = sum_d;
                flags_d[FLG_C] = cy_d;
                flags_d[FLG_Z] = (sum_d == ZERO_W);
            end
            OP_AND, OP_OR, OP_NOR, OP_MOV: begin
                wr_d           = 1'b1;
                result_d       = lres_d;
                flags_d[FLG_C] = 1'b0;
                flags_d[FLG_Z] = (lres_d == ZERO_W);
            end
            OP_CMP: begin
                flags_d[FLG_C] = cy_d;
                flags_d[FLG_Z] = (sum_d == ZERO_W);
                flags_d[FLG_E] = eq_d;
                flags_d[FLG_G] = gt_d;
            end
            default: begin
            end
        endcase
    end

    assign result_o = result_d;
    assign wr_en_o  = wr_d;
    assign flags_o  = flags_d;

    always_comb begin
        AST_CMP_NO_WRITE: assert (!(op_i == OP_CMP) || (!wr_en_o && result_o == ZERO_W)); // R6
        AST_UNUSED_HOLD: assert (!op_i[OPW-1] || (!wr_en_o && flags_o == flags_i && result_o == ZERO_W)); // R9
        AST_ZERO_TRACKS: assert (!wr_en_o || (flags_o[FLG_Z] == (result_o == ZERO_W))); // R7
        AST_EQGT_KEPT: assert (!wr_en_o || (flags_o[FLG_G:FLG_E] == flags_i[FLG_G:FLG_E])); // R8
        AST_EQGT_EXCL: assert (!(op_i == OP_CMP) || !(flags_o[FLG_E] && flags_o[FLG_G])); // R10
        AST_MOV_PASS: assert (!(op_i == OP_MOV) || (result_o == b_i && !flags_o[FLG_C])); // R5
    end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd8;
    logic [7:0] a = 8'h00;
    logic [7:0] b = 8'h00;
    logic [3:0] fin = 4'h0;
    logic [7:0] res;
    logic       wr;
    logic [3:0] fout;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u_dut (
        .op_i(op), .a_i(a), .b_i(b), .flags_i(fin),
        .result_o(res), .wr_en_o(wr), .flags_o(fout)
    );

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h fin=%h actual wr/flags/res=%h expected=%h",
                     req, op, a, b, fin, act, exp);
        end
    endtask

    // Expected {wr, flags, result} derived from the requirement list.
    function automatic logic [12:0] expect_of(input logic [3:0] o, input logic [7:0] x,
                                              input logic [7:0] y, input logic [3:0] f);
        logic [8:0] t;
        logic [7:0] r;
        logic [3:0] nf;
        nf = f;
        r  = 8'h00;
        case (o)
            4'd0: begin t = {1'b0, x} + {1'b0, y}; r = t[7:0]; nf[0] = t[8]; end
            4'd1: begin t = {1'b0, x} + {1'b0, y} + {8'h00, f[0]}; r = t[7:0]; nf[0] = t[8]; end
            4'd2: begin r = x - y; nf[0] = (x < y); end
            4'd3: begin r = x & y; nf[0] = 1'b0; end
            4'd4: begin r = x | y; nf[0] = 1'b0; end
            4'd5: begin r = ~(x | y); nf[0] = 1'b0; end
            4'd7: begin r = y; nf[0] = 1'b0; end
            4'd6: begin
                nf[0] = (x < y); nf[1] = (x == y); nf[2] = (x == y); nf[3] = (x > y);
                return {1'b0, nf, 8'h00};
            end
            default: return {1'b0, f, 8'h00};
        endcase
        nf[1] = (r == 8'h00);
        return {1'b1, nf, r};
    endfunction

    task automatic apply(input string req, input logic [3:0] o, input logic [7:0] x,
                         input logic [7:0] y, input logic [3:0] f);
        @(posedge clk);
        op = o; a = x; b = y; fin = f;
        @(negedge clk);
        check(req, {wr, fout, res}, expect_of(o, x, y, f));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R9", {wr, fout, res}, {1'b0, 4'h0, 8'h00});
    endtask

    task automatic t_add();
        apply("R1", 4'd0, 8'h12, 8'h34, 4'h0);
        apply("R1", 4'd0, 8'hFF, 8'h01, 4'hC);   // wrap to zero, carry out, R7
        @(negedge clk);
        check("R1", {wr, fout, res}, {1'b1, 4'b1111, 8'h00});
        apply("R1", 4'd0, 8'h80, 8'h80, 4'h1);
    endtask

    task automatic t_adc();
        apply("R2", 4'd1, 8'h10, 8'h20, 4'h1);
        @(negedge clk);
        check("R2", {wr, fout, res}, {1'b1, 4'b0000, 8'h31});
        apply("R2", 4'd1, 8'hFE, 8'h01, 4'h1);
        apply("R2", 4'd1, 8'hFE, 8'h01, 4'h0);
    endtask

    task automatic t_sub();
        apply("R3", 4'd2, 8'h05, 8'h03, 4'h0);
        apply("R3", 4'd2, 8'h03, 8'h05, 4'h0);
        @(negedge clk);
        check("R3", {wr, fout, res}, {1'b1, 4'b0001, 8'hFE});
        apply("R3", 4'd2, 8'h7F, 8'h7F, 4'hC);
    endtask

    task automatic t_logic();
        apply("R4", 4'd3, 8'hF0, 8'h3C, 4'h1);
        apply("R4", 4'd4, 8'hF0, 8'h0F, 4'h5);
        apply("R4", 4'd5, 8'h00, 8'h00, 4'h1);
        @(negedge clk);
        check("R4", {wr, fout, res}, {1'b1, 4'b0000, 8'hFF});
        apply("R4", 4'd5, 8'hF0, 8'h0F, 4'h8);
        apply("R7", 4'd3, 8'hAA, 8'h55, 4'h0);
    endtask

    task automatic t_mov();
        apply("R5", 4'd7, 8'h11, 8'hA5, 4'h1);
        apply("R5", 4'd7, 8'h11, 8'h00, 4'hD);
        @(negedge clk);
        check("R5", {wr, fout, res}, {1'b1, 4'b1110, 8'h00});
    endtask

    task automatic t_cmp();
        apply("R6", 4'd6, 8'h40, 8'h40, 4'h0);
        @(negedge clk);
        check("R6", {wr, fout, res}, {1'b0, 4'b0110, 8'h00});
        apply("R6", 4'd6, 8'h41, 8'h40, 4'h7);
        @(negedge clk);
        check("R10", {wr, fout, res}, {1'b0, 4'b1000, 8'h00});
        apply("R6", 4'd6, 8'h00, 8'hFF, 4'h8);
    endtask

    task automatic t_keep_eqgt();
        for (int o = 0; o < 8; o++) begin
            if (o != 6) apply("R8", o[3:0], 8'h3C, 8'h5A, 4'hC);
        end
    endtask

    task automatic t_unused();
        for (int o = 8; o < 16; o++) begin
            apply("R9", o[3:0], 8'hFF, 8'h01, o[3:0] ^ 4'h5);
        end
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 24; k++) begin
                apply("R10", o[3:0], 8'(k * 37 + o), 8'(k * 91 + 3), 4'(k));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_adc();
        t_sub();
        t_logic();
        t_mov();
        t_cmp();
        t_keep_eqgt();
        t_unused();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule